// File: doc/BRIEF.md
# Type-C Lane Routing Controller

This block turns four slow strap pins into the digital routing controls of a USB Type-C alternate-mode crossbar. Two mode pins choose between power-down, USB only, four-lane DisplayPort and USB combined with two-lane DisplayPort. An orientation pin chooses between the two ways a cable can be plugged in. A fourth pin hands control to a register path elsewhere. For each of the four connector-side pairs, the block drives an enable and a source code. It also drives an enable and a pair choice for the host SuperSpeed receive path, and a close/swap pair for the AUX-to-sideband switch.

After reset the block holds USB-only routing whatever the mode pins say. It gives up that default only after it has watched the low mode pin go low, then high, then low again. The sideband switch closes while the upper mode pin is high. It opens only after that pin has stayed low longer than a timeout set by the clock frequency. All pins are resynchronised before use, so every output is registered and moves a fixed number of cycles after the pins.

Top module: `tcx_route_ctrl`

## Requirements
- R1: After reset, and until the release sequence of R2 completes, routing is USB-only (see R4) for the current orientation pin, whatever the mode pins say. In this state the sideband switch stays open.
- R2: The USB default is released only after the synchronised `mode_lo_i` is observed low, then high, then low. A single high-to-low transition starting from a pin held high at reset does not release it.
- R3: Mode pins `{mode_hi_i, mode_lo_i}` = 00 (power-down) enable no connector output and no host receive path.
- R4: Mode 01 (USB only). Without flip: `ssrx_sel_o`=0 (connector pair 1) and connector TX1 carries host transmit. With flip: `ssrx_sel_o`=1 and TX2 carries host transmit. `ssrx_en_o`=1 and all other outputs are disabled. Connector index is RX1=0, TX1=1, RX2=2, TX2=3. The source code of index i sits at `con_sel_o[3i+2:3i]`: 0 none, 1 host transmit, 2..5 DisplayPort lanes 0..3.
- R5: Mode 10 without flip routes DP lane 0 to RX2, lane 1 to TX2, lane 2 to TX1 and lane 3 to RX1. The host receive path is disabled.
- R6: Mode 10 with flip routes DP lane 0 to RX1, lane 1 to TX1, lane 2 to TX2 and lane 3 to RX2.
- R7: Mode 11 without flip uses pair 1 for USB (`ssrx_sel_o`=0, TX1 host transmit) and routes DP lane 0 to RX2 and lane 1 to TX2. With flip, USB uses pair 2 (`ssrx_sel_o`=1, TX2 host transmit) and DP lanes 0 and 1 go to RX1 and TX1.
- R8: Once released, while `mode_hi_i` is high the sideband switch is closed (`sbu_en_o`=1) and `sbu_swap_o` equals the orientation pin. 0 means AUX+ to SBU1; 1 means crossed.
- R9: While `mode_hi_i` is low, the switch keeps its previous closed state and swap until the low period exceeds `CLK_HZ/1000*TIMEOUT_MS` cycles. After that it opens.
- R10: While `i2c_en_i` is high, all lane enables, the host receive enable and the sideband switch are driven off. Dropping it restores the pin decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, stands in for power-up |
| mode_hi_i | input | 1 | Upper mode pin; high enables DisplayPort |
| mode_lo_i | input | 1 | Lower mode pin; its pulse releases the USB default |
| flip_i | input | 1 | Cable orientation pin |
| i2c_en_i | input | 1 | High hands routing to the register path; pin decode off |
| con_en_o | output | 4 | Per connector output enable, index RX1,TX1,RX2,TX2 |
| con_sel_o | output | 12 | Per connector 3-bit source code |
| ssrx_en_o | output | 1 | Host SuperSpeed receive path enable |
| ssrx_sel_o | output | 1 | Host receive source: 0 pair 1, 1 pair 2 |
| sbu_en_o | output | 1 | Sideband switch closed |
| sbu_swap_o | output | 1 | Sideband crossed mapping |

## Verification
A pin change reaches the routing outputs on the third rising clock edge: two synchroniser stages and one output register. A release sequence takes one extra edge, because the tracker state sits between the synchronised pin and the output register. The sideband switch opens on roughly the timeout-plus-three edge after the upper mode pin falls. The driver holds each pin pattern for at least five clock periods before it queues the expected value, so every check samples after its latest due edge. The timeout checks use lows well under and well over the limit, so none of them hinges on the exact boundary cycle.

// File: rtl/tcx_pkg.sv
package tcx_pkg;

    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_USB = 2'b01,
        MODE_DP4 = 2'b10,
        MODE_MIX = 2'b11
    } mode_e;

    localparam int NUM_CON  = 4;
    localparam int SEL_W    = 3;

    localparam int CON_RX1  = 0;
    localparam int CON_TX1  = 1;
    localparam int CON_RX2  = 2;
    localparam int CON_TX2  = 3;

    localparam logic [SEL_W-1:0] SRC_NONE   = 3'd0;
    localparam logic [SEL_W-1:0] SRC_HOSTTX = 3'd1;
    localparam logic [SEL_W-1:0] SRC_DP0    = 3'd2;
    localparam logic [SEL_W-1:0] SRC_DP1    = 3'd3;
    localparam logic [SEL_W-1:0] SRC_DP2    = 3'd4;
    localparam logic [SEL_W-1:0] SRC_DP3    = 3'd5;

    typedef struct packed {
        logic [NUM_CON-1:0]            en;
        logic [NUM_CON-1:0][SEL_W-1:0] sel;
        logic                          ssrx_en;
        logic                          ssrx_sel;
    } route_t;

endpackage

// File: rtl/tcx_pin_sync.sv
module tcx_pin_sync #(
    parameter int          WIDTH   = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.s2;

endmodule

// File: rtl/tcx_mode_track.sv
module tcx_mode_track (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_s_i,
    output logic released_o
);

    typedef enum logic [1:0] {
        TRK_WAIT_LOW  = 2'd0,
        TRK_WAIT_HIGH = 2'd1,
        TRK_WAIT_FALL = 2'd2,
        TRK_FREE      = 2'd3
    } trk_e;

    typedef struct packed {
        trk_e st;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        unique case (trk_q.st)
            TRK_WAIT_LOW:  if (!lo_s_i) trk_d.st = TRK_WAIT_HIGH;
            TRK_WAIT_HIGH: if (lo_s_i)  trk_d.st = TRK_WAIT_FALL;
            TRK_WAIT_FALL: if (!lo_s_i) trk_d.st = TRK_FREE;
            TRK_FREE:      trk_d.st = TRK_FREE;
            default:       trk_d.st = TRK_WAIT_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{st: TRK_WAIT_LOW};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign released_o = (trk_q.st == TRK_FREE);

    AST_FREE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        released_o |=> released_o); // R2
    AST_RELEASE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(released_o) |-> !$past(lo_s_i)); // R2
    AST_ARM_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.st == TRK_WAIT_FALL) |-> $past(lo_s_i)); // R2

endmodule

// File: rtl/tcx_aux_timer.sv
module tcx_aux_timer #(
    parameter int LIMIT = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_s_i,
    input  logic flip_s_i,
    input  logic allow_i,
    output logic aux_en_o,
    output logic aux_swap_o
);

    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en;
        logic             swap;
    } aux_t;

    aux_t aux_d, aux_q;
    logic expired;

    always_comb begin
        aux_d   = aux_q;
        expired = (aux_q.cnt == CNT_MAX);

        if (hi_s_i) begin
            aux_d.cnt = '0;
        end else if (!expired) begin
            aux_d.cnt = aux_q.cnt + 1'b1;
        end

        if (!allow_i) begin
            aux_d.en   = 1'b0;
            aux_d.swap = 1'b0;
        end else if (hi_s_i) begin
            aux_d.en   = 1'b1;
            aux_d.swap = flip_s_i;
        end else if (expired) begin
            aux_d.en   = 1'b0;
            aux_d.swap = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aux_q <= '{cnt: '0, en: 1'b0, swap: 1'b0};
        end else begin
            aux_q <= aux_d;
        end
    end

    assign aux_en_o   = aux_q.en;
    assign aux_swap_o = aux_q.swap;

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        hi_s_i |=> (aux_q.cnt == '0)); // R9
    AST_AUX_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (allow_i && hi_s_i) |=> (aux_en_o && (aux_swap_o == $past(flip_s_i)))); // R8
    AST_OPEN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(aux_en_o) && $past(allow_i)) |-> ($past(aux_q.cnt) == CNT_MAX)); // R9
    AST_SWAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (allow_i && !hi_s_i && aux_q.cnt != CNT_MAX) |=> $stable(aux_swap_o)); // R9

endmodule

// File: rtl/tcx_lane_decode.sv
module tcx_lane_decode
    import tcx_pkg::*;
(
    input  mode_e  mode_i,
    input  logic   flip_i,
    output route_t route_o
);

    always_comb begin
        route_o = '0;
        unique case (mode_i)
            MODE_OFF: begin
                route_o = '0;
            end
            MODE_USB: begin
                route_o.ssrx_en  = 1'b1;
                route_o.ssrx_sel = flip_i;
                if (!flip_i) begin
                    route_o.en[CON_TX1]  = 1'b1;
                    route_o.sel[CON_TX1] = SRC_HOSTTX;
                end else begin
                    route_o.en[CON_TX2]  = 1'b1;
                    route_o.sel[CON_TX2] = SRC_HOSTTX;
                end
            end
            MODE_DP4: begin
                route_o.en = '1;
                if (!flip_i) begin
                    route_o.sel[CON_RX2] = SRC_DP0;
                    route_o.sel[CON_TX2] = SRC_DP1;
                    route_o.sel[CON_TX1] = SRC_DP2;
                    route_o.sel[CON_RX1] = SRC_DP3;
                end else begin
                    route_o.sel[CON_RX1] = SRC_DP0;
                    route_o.sel[CON_TX1] = SRC_DP1;
                    route_o.sel[CON_TX2] = SRC_DP2;
                    route_o.sel[CON_RX2] = SRC_DP3;
                end
            end
            MODE_MIX: begin
                route_o.en       = '1;
                route_o.ssrx_en  = 1'b1;
                route_o.ssrx_sel = flip_i;
                route_o.en[flip_i ? CON_RX2 : CON_RX1] = 1'b0;
                if (!flip_i) begin
                    route_o.sel[CON_TX1] = SRC_HOSTTX;
                    route_o.sel[CON_RX2] = SRC_DP0;
                    route_o.sel[CON_TX2] = SRC_DP1;
                end else begin
                    route_o.sel[CON_TX2] = SRC_HOSTTX;
                    route_o.sel[CON_RX1] = SRC_DP0;
                    route_o.sel[CON_TX1] = SRC_DP1;
                end
            end
            default: route_o = '0;
        endcase
    end

endmodule

// File: rtl/tcx_route_ctrl.sv
module tcx_route_ctrl
    import tcx_pkg::*;
#(
    parameter int CLK_HZ     = 100_000_000,
    parameter int TIMEOUT_MS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_hi_i,
    input  logic        mode_lo_i,
    input  logic        flip_i,
    input  logic        i2c_en_i,
    output logic [3:0]  con_en_o,
    output logic [11:0] con_sel_o,
    output logic        ssrx_en_o,
    output logic        ssrx_sel_o,
    output logic        sbu_en_o,
    output logic        sbu_swap_o
);

    localparam int LIMIT  = (CLK_HZ / 1000) * TIMEOUT_MS;
    localparam int PIN_W  = 4;
    localparam int P_LO   = 0;
    localparam int P_HI   = 1;
    localparam int P_FLIP = 2;
    localparam int P_I2C  = 3;
    // lower mode pin resets high so a genuine low must be observed first
    localparam logic [PIN_W-1:0] PIN_RST = PIN_W'(1) << P_LO;

    logic [PIN_W-1:0] pins_s;
    logic             released;
    logic             allow_aux;
    mode_e            mode_eff;
    route_t           dec_route;

    typedef struct packed {
        route_t route;
    } out_t;

    out_t out_d, out_q;

    tcx_pin_sync #(
        .WIDTH   (PIN_W),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({i2c_en_i, flip_i, mode_hi_i, mode_lo_i}),
        .sync_o (pins_s)
    );

    tcx_mode_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .lo_s_i     (pins_s[P_LO]),
        .released_o (released)
    );

    always_comb begin
        if (pins_s[P_I2C]) begin
            mode_eff = MODE_OFF;
        end else if (!released) begin
            mode_eff = MODE_USB;
        end else begin
            mode_eff = mode_e'({pins_s[P_HI], pins_s[P_LO]});
        end
    end

    tcx_lane_decode u_decode (
        .mode_i  (mode_eff),
        .flip_i  (pins_s[P_FLIP]),
        .route_o (dec_route)
    );

    assign allow_aux = released && !pins_s[P_I2C];

    tcx_aux_timer #(
        .LIMIT (LIMIT)
    ) u_aux (
        .clk        (clk),
        .rst_n      (rst_n),
        .hi_s_i     (pins_s[P_HI]),
        .flip_s_i   (pins_s[P_FLIP]),
        .allow_i    (allow_aux),
        .aux_en_o   (sbu_en_o),
        .aux_swap_o (sbu_swap_o)
    );

    always_comb begin
        out_d       = out_q;
        out_d.route = dec_route;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign con_en_o   = out_q.route.en;
    assign con_sel_o  = out_q.route.sel;
    assign ssrx_en_o  = out_q.route.ssrx_en;
    assign ssrx_sel_o = out_q.route.ssrx_sel;

    logic [NUM_CON-1:0] host_use;
    always_comb begin
        for (int i = 0; i < NUM_CON; i++) begin
            host_use[i] = con_en_o[i] && (out_q.route.sel[i] == SRC_HOSTTX);
        end
    end

    AST_I2C_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pins_s[P_I2C] |=> (con_en_o == '0 && !ssrx_en_o && !sbu_en_o)); // R10
    AST_DEFAULT_USB: assert property (@(posedge clk) disable iff (!rst_n)
        (!released && !pins_s[P_I2C]) |=> (ssrx_en_o && !sbu_en_o)); // R1
    AST_HOST_TX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(host_use)); // R4
    AST_HOST_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        ssrx_en_o |-> ($countones(host_use) == 1)); // R7
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (released && !pins_s[P_I2C] && !pins_s[P_HI] && !pins_s[P_LO])
        |=> (con_en_o == '0 && !ssrx_en_o)); // R3

endmodule

// File: tb/tcx_route_ctrl_tb.sv
module tcx_route_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_hi = 1'b0, mode_lo = 1'b0, flip = 1'b0, i2c_en = 1'b0;
    logic [3:0]  con_en;
    logic [11:0] con_sel;
    logic        ssrx_en, ssrx_sel, sbu_en, sbu_swap;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    localparam int LIM = 20; // 10 kHz * 2 ms

    always #5 clk = ~clk;

    tcx_route_ctrl #(.CLK_HZ(10_000), .TIMEOUT_MS(2)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .mode_hi_i(mode_hi), .mode_lo_i(mode_lo), .flip_i(flip), .i2c_en_i(i2c_en),
        .con_en_o(con_en), .con_sel_o(con_sel),
        .ssrx_en_o(ssrx_en), .ssrx_sel_o(ssrx_sel),
        .sbu_en_o(sbu_en), .sbu_swap_o(sbu_swap)
    );

    typedef struct {
        logic [19:0] v;
        string       tag;
    } item_t;

    item_t sb_q[$];

    // Expected outputs from the requirement tables: m 0 off,1 usb,2 dp4,3 mix
    function automatic logic [19:0] expv(int m, bit f, bit ae, bit as);
        logic [3:0]  en  = '0;
        logic [11:0] sel = '0;
        bit          se  = 0;
        bit          ss  = 0;
        case (m)
            1: begin
                se = 1; ss = f;
                if (!f) begin en[1] = 1; sel[3+:3] = 3'd1; end
                else    begin en[3] = 1; sel[9+:3] = 3'd1; end
            end
            2: begin
                en = 4'b1111;
                if (!f) begin
                    sel[6+:3] = 3'd2; sel[9+:3] = 3'd3; sel[3+:3] = 3'd4; sel[0+:3] = 3'd5;
                end else begin
                    sel[0+:3] = 3'd2; sel[3+:3] = 3'd3; sel[9+:3] = 3'd4; sel[6+:3] = 3'd5;
                end
            end
            3: begin
                se = 1; ss = f;
                if (!f) begin
                    en = 4'b1110; sel[3+:3] = 3'd1; sel[6+:3] = 3'd2; sel[9+:3] = 3'd3;
                end else begin
                    en = 4'b1011; sel[9+:3] = 3'd1; sel[0+:3] = 3'd2; sel[3+:3] = 3'd3;
                end
            end
            default: ;
        endcase
        return {en, sel, se, ss, ae, as};
    endfunction

    task automatic drive(bit c1, bit c0, bit f, bit i2, int hold, string tag,
                         int m, bit ae, bit as);
        item_t it;
        @(negedge clk);
        mode_hi = c1; mode_lo = c0; flip = f; i2c_en = i2;
        repeat (hold) @(negedge clk);
        #1;
        it.v   = expv(m, f, ae, as);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic do_reset(bit c1, bit c0, bit f);
        @(negedge clk);
        rst_n = 0;
        mode_hi = c1; mode_lo = c0; flip = f; i2c_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    // monitor: pop one expectation per falling edge and compare
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [19:0] act;
            it  = sb_q.pop_front();
            act = {con_en, con_sel, ssrx_en, ssrx_sel, sbu_en, sbu_swap};
            checks++;
            if (act !== it.v) begin
                failures++;
                $display("FAIL %s actual=%05h expected=%05h", it.tag, act, it.v);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // reset value while held in reset
        rst_n = 0;
        mode_hi = 1; mode_lo = 1;
        repeat (2) @(negedge clk);
        checks++;
        if ({con_en, ssrx_en, sbu_en} !== 6'b0) begin
            failures++;
            $display("FAIL R1 reset actual=%b expected=0", {con_en, ssrx_en, sbu_en});
        end
        do_reset(1, 1, 0);
        drive(1, 1, 0, 0, 5, "R1 default usb noflip",        1, 0, 0);
        drive(1, 1, 1, 0, 5, "R1 default usb flip",          1, 0, 0);
        drive(1, 0, 0, 0, 5, "R2 lone fall keeps default",   1, 0, 0);
        drive(1, 1, 0, 0, 5, "R2 high keeps default",        1, 0, 0);
        drive(1, 0, 0, 0, 6, "R2 R5 R8 released dp4 noflip", 2, 1, 0);
        drive(1, 0, 1, 0, 5, "R6 R8 dp4 flip",               2, 1, 1);
        drive(1, 1, 1, 0, 5, "R7 mix flip",                  3, 1, 1);
        drive(1, 1, 0, 0, 5, "R7 mix noflip",                3, 1, 0);
        drive(1, 1, 1, 0, 5, "R7 R8 mix flip swap",          3, 1, 1);
        drive(0, 1, 0, 0, 6, "R4 R9 usb noflip aux held",    1, 1, 1);
        drive(0, 1, 1, 0, 6, "R4 R9 usb flip aux held",      1, 1, 1);
        drive(0, 1, 1, 0, LIM + 10, "R9 aux opens",          1, 0, 0);
        drive(0, 0, 0, 0, 5, "R3 power down",                0, 0, 0);
        drive(0, 0, 1, 0, 5, "R3 power down flip",           0, 0, 0);
        drive(1, 1, 0, 0, 5, "R8 close again",               3, 1, 0);
        drive(1, 1, 0, 1, 5, "R10 i2c off",                  0, 0, 0);
        drive(1, 0, 1, 1, 5, "R10 i2c ignores pins",         0, 0, 0);
        drive(1, 1, 0, 0, 5, "R10 i2c released",             3, 1, 0);
        // fresh power-up with the low mode pin low
        do_reset(0, 0, 1);
        drive(0, 0, 1, 0, 5, "R1 default over power down",   1, 0, 0);
        drive(0, 1, 1, 0, 5, "R2 waiting for fall",          1, 0, 0);
        drive(0, 0, 1, 0, 6, "R2 R3 released to off",        0, 0, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule